// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Condition Code

This unit performs one integer shift or rotate per accepted request and presents the result one clock later. A request carries a 3-bit operation code, a 2-bit width code, one or two 64-bit register values, and the parts of an address-style shift amount: a base value, a flag saying whether the base takes part, and a displacement. The effective amount is always six bits wide, for every operand width. As a result, a 32-bit shift by 32 to 63 positions fills the low word with zeros or with sign copies. It does not wrap around to a smaller shift.

Three operand shapes are supported: the low word of one register (32-bit form), a whole register (64-bit form), and a pair of registers (pair form). In the pair form, the low words of two registers are joined into one 64-bit value, and the first register supplies the high half. The arithmetic left and right shifts also produce a 2-bit condition code. The arithmetic left shift keeps the sign bit in place and reports overflow through that code. Logical shifts and rotates leave the registered condition code untouched.

Top module: `srt_unit`

## Requirements
- R1: The shift amount is disp[5:0] when base_vld is 0. When base_vld is 1, it is (base + disp) modulo 64, with disp zero-extended. The upper bits of base and disp do not affect the result.
- R2: With width code 0 (32-bit form), logical shifts (op 0 = left, op 1 = right) by 32..63 give a zero low word. In every 32-bit form, res_hi[63:32] equals opnd_a[63:32], and res_lo equals opnd_b.
- R3: A 32-bit arithmetic right shift (op 3) by 31..63 fills the low word with copies of opnd_a[31].
- R4: The arithmetic left shift (op 2) keeps the operand sign bit in the result's sign position. The remaining bits shift left with zero fill, and bits moved past the sign position are lost.
- R5: The arithmetic left shift gives cc = 3 when any bit shifted out of, or into, the sign position differs from the original sign.
- R6: An arithmetic left shift without overflow gives cc = 0 for a zero result, cc = 1 for a negative result and cc = 2 for a positive result.
- R7: A 64-bit (width code 1) arithmetic left shift by 63 gives a correct result and a correct condition code.
- R8: The arithmetic right shift gives cc 0/1/2 for a zero, negative or positive result. The 32-bit form reads the result as a signed 32-bit value. The 64-bit and pair forms read it as a signed 64-bit value.
- R9: The pair form (width code 2) shifts or rotates the 64-bit value {opnd_a[31:0], opnd_b[31:0]}. The high half of the result goes to res_hi[31:0] and the low half to res_lo[31:0]. Both upper words pass through unchanged.
- R10: Rotate left (op 4) uses the amount modulo 32 in the 32-bit form and modulo 64 in the 64-bit and pair forms.
- R11: After an accepted logical shift or rotate, cc_valid is 0 and cc keeps its previous value. After an arithmetic shift, cc_valid is 1.
- R12: out_valid is in_valid delayed by one clock. While in_valid is 0, the result outputs and cc hold their values. Reset clears out_valid, cc_valid and cc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request accepted this cycle |
| op_sel | input | 3 | 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left |
| width_sel | input | 2 | 0 low word, 1 whole register, 2 register pair |
| opnd_a | input | 64 | Source register, or the high-half register of a pair |
| opnd_b | input | 64 | Low-half register of a pair; passed through otherwise |
| base | input | 64 | Base value for the amount |
| base_vld | input | 1 | Add base into the amount |
| disp | input | 20 | Displacement |
| out_valid | output | 1 | Result registers updated last cycle |
| res_hi | output | 64 | New value of the first register |
| res_lo | output | 64 | New value of the second register |
| cc | output | 2 | Condition code |
| cc_valid | output | 1 | Last result carried a new condition code |

## Verification
The bench targets 32-bit shifts by 32 and above. A design that masks the amount to five bits would return the operand unshifted or only slightly shifted. It also targets arithmetic left shifts at the sign boundary and at amount 63. A mask built one bit too wide there would miss the overflow or report it falsely. Pair-form cases make sure the two halves are not swapped and that the upper words are not lost. Rotates by more than 31 in the 32-bit form check that the amount wraps modulo 32. A logical shift after an overflow checks that the held code is not overwritten.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    OP_SLL = 3'd0,
    OP_SRL = 3'd1,
    OP_SLA = 3'd2,
    OP_SRA = 3'd3,
    OP_ROL = 3'd4
  } srt_op_e;

  typedef enum logic [1:0] {
    W_32   = 2'd0,
    W_64   = 2'd1,
    W_PAIR = 2'd2
  } srt_w_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_NEG  = 2'd1,
    CC_POS  = 2'd2,
    CC_OVF  = 2'd3
  } srt_cc_e;
endpackage

// File: rtl/srt_amount.sv
module srt_amount #(
  parameter int BASE_W = 64,
  parameter int DISP_W = 20,
  parameter int AMT_W  = 6
) (
  input  logic [BASE_W-1:0] base,
  input  logic              base_vld,
  input  logic [DISP_W-1:0] disp,
  output logic [AMT_W-1:0]  amt
);
  logic [AMT_W-1:0] sum_lo;

  // Only the low bits of the address survive the final mask, so add narrow.
  always_comb begin
    sum_lo = base[AMT_W-1:0] + disp[AMT_W-1:0];
    amt    = base_vld ? sum_lo : disp[AMT_W-1:0];
  end
endmodule

// File: rtl/srt_core.sv
module srt_core
  import srt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AMT_W = $clog2(XLEN)
) (
  input  logic [2:0]       op_sel,
  input  logic [1:0]       width_sel,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [AMT_W-1:0] amt,
  output logic [XLEN-1:0]  nxt_hi,
  output logic [XLEN-1:0]  nxt_lo,
  output logic [1:0]       nxt_cc,
  output logic             cc_en
);
  localparam int HALF = XLEN / 2;

  srt_op_e          op;
  srt_w_e           wd;
  logic             narrow;
  logic [HALF-1:0]  lo_a;
  logic [XLEN-1:0]  full_v, sext_v, ljust_v;
  logic [XLEN-1:0]  sll_r, srl_r, sra_r;
  logic [XLEN-1:0]  sla_t, sla_back, sla_r;
  logic             sla_ovf;
  logic [2*XLEN-1:0] rot_w;
  logic [XLEN-1:0]  rot_n, rot_r;
  logic [XLEN-1:0]  res;
  logic [XLEN-1:0]  view;

  always_comb begin
    op      = srt_op_e'(op_sel);
    wd      = srt_w_e'(width_sel);
    narrow  = (wd == W_32);
    lo_a    = opnd_a[HALF-1:0];

    if (narrow)           full_v = {{HALF{1'b0}}, lo_a};
    else if (wd == W_PAIR) full_v = {lo_a, opnd_b[HALF-1:0]};
    else                  full_v = opnd_a;

    sext_v  = narrow ? {{HALF{lo_a[HALF-1]}}, lo_a} : full_v;
    ljust_v = narrow ? {lo_a, {HALF{1'b0}}} : full_v;

    sll_r   = full_v << amt;
    srl_r   = full_v >> amt;
    sra_r   = XLEN'($signed(sext_v) >>> amt);

    // Arithmetic left: shift a left-justified copy, shift back with sign
    // fill; any difference means a bit unlike the sign crossed the top.
    sla_t    = ljust_v << amt;
    sla_back = XLEN'($signed(sla_t) >>> amt);
    sla_ovf  = (sla_back != ljust_v);
    sla_r    = {ljust_v[XLEN-1], sla_t[XLEN-2:0]};

    rot_w   = narrow ? {{XLEN{1'b0}}, lo_a, lo_a} << amt[AMT_W-2:0]
                     : {full_v, full_v} << amt;
    rot_n   = {{HALF{1'b0}}, rot_w[XLEN-1:HALF]};
    rot_r   = narrow ? rot_n : rot_w[2*XLEN-1:XLEN];

    case (op)
      OP_SRL:  res = srl_r;
      OP_SRA:  res = sra_r;
      OP_SLA:  res = narrow ? {{HALF{1'b0}}, sla_r[XLEN-1:HALF]} : sla_r;
      OP_ROL:  res = rot_r;
      default: res = sll_r;
    endcase

    view   = narrow ? {{HALF{res[HALF-1]}}, res[HALF-1:0]} : res;
    cc_en  = (op == OP_SLA) || (op == OP_SRA);
    if ((op == OP_SLA) && sla_ovf) nxt_cc = CC_OVF;
    else if (view == '0)           nxt_cc = CC_ZERO;
    else if (view[XLEN-1])         nxt_cc = CC_NEG;
    else                           nxt_cc = CC_POS;

    case (wd)
      W_32: begin
        nxt_hi = {opnd_a[XLEN-1:HALF], res[HALF-1:0]};
        nxt_lo = opnd_b;
      end
      W_PAIR: begin
        nxt_hi = {opnd_a[XLEN-1:HALF], res[XLEN-1:HALF]};
        nxt_lo = {opnd_b[XLEN-1:HALF], res[HALF-1:0]};
      end
      default: begin
        nxt_hi = res;
        nxt_lo = opnd_b;
      end
    endcase
  end

  always_comb begin
    if (op == OP_SLA) begin
      // R4
      sign_keep_chk: assert (res[narrow ? HALF-1 : XLEN-1] == (narrow ? lo_a[HALF-1] : full_v[XLEN-1]));
    end
    if (narrow && ((op == OP_SLL) || (op == OP_SRL)) && amt[AMT_W-1]) begin
      // R2
      wide_amt_zero_chk: assert (nxt_hi[HALF-1:0] == '0);
    end
    if (narrow && (op == OP_SRA) && (amt >= AMT_W'(HALF-1))) begin
      // R3
      sign_fill_chk: assert (nxt_hi[HALF-1:0] == {HALF{lo_a[HALF-1]}});
    end
  end
endmodule

// File: rtl/srt_rst_sync.sv
module srt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srt_unit.sv
module srt_unit
  import srt_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        width_sel,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [XLEN-1:0]   base,
  input  logic              base_vld,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic [XLEN-1:0]   res_hi,
  output logic [XLEN-1:0]   res_lo,
  output logic [1:0]        cc,
  output logic              cc_valid
);
  localparam int AMT_W = $clog2(XLEN);

  logic             rst_sync_n;
  logic [AMT_W-1:0] amt;
  logic [XLEN-1:0]  c_hi, c_lo;
  logic [1:0]       c_cc;
  logic             c_cc_en;

  logic             vld_q, vld_d;
  logic [XLEN-1:0]  hi_q, hi_d, lo_q, lo_d;
  logic [1:0]       cc_q, cc_d;
  logic             ccv_q, ccv_d;

  srt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  srt_amount #(.BASE_W(XLEN), .DISP_W(DISP_W), .AMT_W(AMT_W)) u_amt (
    .base(base), .base_vld(base_vld), .disp(disp), .amt(amt)
  );

  srt_core #(.XLEN(XLEN), .AMT_W(AMT_W)) u_core (
    .op_sel(op_sel), .width_sel(width_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .amt(amt), .nxt_hi(c_hi), .nxt_lo(c_lo), .nxt_cc(c_cc), .cc_en(c_cc_en)
  );

  always_comb begin
    vld_d = in_valid;
    hi_d  = hi_q;
    lo_d  = lo_q;
    cc_d  = cc_q;
    ccv_d = ccv_q;
    if (in_valid) begin
      hi_d  = c_hi;
      lo_d  = c_lo;
      ccv_d = c_cc_en;
      if (c_cc_en) cc_d = c_cc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
      cc_q  <= '0;
      ccv_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      cc_q  <= cc_d;
      ccv_q <= ccv_d;
    end
  end

  assign out_valid = vld_q;
  assign res_hi    = hi_q;
  assign res_lo    = lo_q;
  assign cc        = cc_q;
  assign cc_valid  = ccv_q;

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(res_hi) && $stable(res_lo) && $stable(cc)));
  // R11
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (op_sel == OP_SLL || op_sel == OP_SRL || op_sel == OP_ROL))
      |=> ($stable(cc) && !cc_valid));
endmodule

// File: tb/srt_unit_test.sv
module srt_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [1:0]  width_sel;
  logic [63:0] opnd_a, opnd_b, base;
  logic        base_vld;
  logic [19:0] disp;
  logic        out_valid, cc_valid;
  logic [63:0] res_hi, res_lo;
  logic [1:0]  cc;

  int total = 0;
  int bad = 0;
  logic [1:0] exp_cc;

  always #(CLK_PERIOD/2) clk = ~clk;

  srt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .width_sel(width_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .base(base),
    .base_vld(base_vld), .disp(disp), .out_valid(out_valid),
    .res_hi(res_hi), .res_lo(res_lo), .cc(cc), .cc_valid(cc_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Bit-level reference built from the requirements.
  task automatic ref_op(input logic [2:0] op, input logic [1:0] w,
                        input logic [63:0] a, input logic [63:0] b, input int amt,
                        output logic [63:0] hi, output logic [63:0] lo,
                        output logic has_cc, output logic [1:0] ccv);
    logic [63:0] x, r;
    int n;
    logic ovf;
    n   = (w == 2'd0) ? 32 : 64;
    x   = (w == 2'd0) ? {32'b0, a[31:0]} : (w == 2'd2) ? {a[31:0], b[31:0]} : a;
    r   = '0;
    ovf = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd1: r[i] = (i + amt < n) ? x[i+amt] : 1'b0;
        3'd3: r[i] = (i + amt < n) ? x[i+amt] : x[n-1];
        3'd4: r[i] = x[(i - (amt % n) + n) % n];
        3'd2: r[i] = (i == n-1) ? x[n-1] : ((i >= amt) ? x[i-amt] : 1'b0);
        default: r[i] = (i >= amt) ? x[i-amt] : 1'b0;
      endcase
    end
    for (int j = 0; j < n-1; j++)
      if (j + amt >= n-1 && x[j] != x[n-1]) ovf = 1'b1;
    has_cc = (op == 3'd2) || (op == 3'd3);
    if (op == 3'd2 && ovf) ccv = 2'd3;
    else if (r == 64'd0)   ccv = 2'd0;
    else if (r[n-1])       ccv = 2'd1;
    else                   ccv = 2'd2;
    case (w)
      2'd0:    begin hi = {a[63:32], r[31:0]}; lo = b; end
      2'd2:    begin hi = {a[63:32], r[63:32]}; lo = {b[63:32], r[31:0]}; end
      default: begin hi = r; lo = b; end
    endcase
  endtask

  task automatic go(input string tag, input logic [2:0] op, input logic [1:0] w,
                    input logic [63:0] a, input logic [63:0] b,
                    input logic [63:0] bs, input logic bv, input logic [19:0] d);
    logic [63:0] ehi, elo;
    logic        ehc;
    logic [1:0]  ecc;
    logic [5:0]  amt;
    amt = bv ? 6'(bs[5:0] + d[5:0]) : d[5:0];
    ref_op(op, w, a, b, int'(amt), ehi, elo, ehc, ecc);
    if (ehc) exp_cc = ecc;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; width_sel = w; opnd_a = a; opnd_b = b;
    base = bs; base_vld = bv; disp = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk({tag, " out_valid"}, 64'(out_valid), 64'd1);
    chk({tag, " res_hi"}, res_hi, ehi);
    chk({tag, " res_lo"}, res_lo, elo);
    chk({tag, " cc_valid"}, 64'(cc_valid), 64'(ehc));
    chk({tag, " cc"}, 64'(cc), 64'(exp_cc));
  endtask

  task automatic t_reset;
    chk("R12 reset out_valid", 64'(out_valid), 64'd0);
    chk("R12 reset cc_valid", 64'(cc_valid), 64'd0);
    chk("R12 reset cc", 64'(cc), 64'd0);
  endtask

  task automatic t_amount;
    go("R1 base+disp", 3'd0, 2'd1, 64'h1, 64'h0, 64'h3F, 1'b1, 20'h00002);
    go("R1 disp only", 3'd0, 2'd1, 64'h1, 64'h0, 64'h5, 1'b0, 20'hFFF47);
    go("R1 high bits", 3'd1, 2'd1, 64'hF000_0000_0000_0000, 64'h0,
       64'hFFFF_FFFF_FFFF_FFC4, 1'b1, 20'h80001);
  endtask

  task automatic t_big32;
    go("R2 sll32 by 32", 3'd0, 2'd0, 64'hDEAD_BEEF_0000_0001, 64'h77, 64'h0, 1'b0, 20'd32);
    go("R2 srl32 by 40", 3'd1, 2'd0, 64'h1234_5678_FFFF_FFFF, 64'h0, 64'h0, 1'b0, 20'd40);
    go("R2 sll32 by 31", 3'd0, 2'd0, 64'hCAFE_0000_0000_0003, 64'h0, 64'h0, 1'b0, 20'd31);
  endtask

  task automatic t_sra32;
    go("R3 sra32 neg 45", 3'd3, 2'd0, 64'h0000_0001_8000_0000, 64'h0, 64'h0, 1'b0, 20'd45);
    go("R3 sra32 pos 63", 3'd3, 2'd0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 64'h0, 1'b0, 20'd63);
  endtask

  task automatic t_sla;
    go("R6 sla pos", 3'd2, 2'd0, 64'h0000_0000_0000_0003, 64'h0, 64'h0, 1'b0, 20'd2);
    go("R6 sla neg", 3'd2, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0, 64'h0, 1'b0, 20'd4);
    go("R6 sla zero", 3'd2, 2'd0, 64'h0, 64'h0, 64'h0, 1'b0, 20'd5);
    go("R5 sla ovf into sign", 3'd2, 2'd0, 64'h4000_0000, 64'h0, 64'h0, 1'b0, 20'd1);
    go("R5 sla32 by 32", 3'd2, 2'd0, 64'h1, 64'h0, 64'h0, 1'b0, 20'd32);
    go("R4 sla keeps sign", 3'd2, 2'd1, 64'h8000_0000_0000_0001, 64'h0, 64'h0, 1'b0, 20'd3);
  endtask

  task automatic t_sla63;
    go("R7 sla63 ovf", 3'd2, 2'd1, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 1'b0, 20'd63);
    go("R7 sla63 all ones", 3'd2, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0, 20'd63);
    go("R7 sla63 zero", 3'd2, 2'd1, 64'h0, 64'h0, 64'h0, 1'b0, 20'd63);
  endtask

  task automatic t_sra_cc;
    go("R8 sra64 neg", 3'd3, 2'd1, 64'hF000_0000_0000_0000, 64'h0, 64'h0, 1'b0, 20'd4);
    go("R8 sra32 pos", 3'd3, 2'd0, 64'h8000_0000_7000_0000, 64'h0, 64'h0, 1'b0, 20'd4);
    go("R8 sra pair neg", 3'd3, 2'd2, 64'h0000_0000_8000_0000, 64'h0, 64'h0, 1'b0, 20'd8);
  endtask

  task automatic t_pair;
    go("R9 pair sll", 3'd0, 2'd2, 64'hAAAA_AAAA_0000_0001, 64'h5555_5555_8000_0000,
       64'h0, 1'b0, 20'd1);
    go("R9 pair srl", 3'd1, 2'd2, 64'h1111_1111_1234_5678, 64'h2222_2222_9ABC_DEF0,
       64'h0, 1'b0, 20'd36);
    go("R9 pair sla", 3'd2, 2'd2, 64'h0, 64'h0000_0000_0000_0005, 64'h0, 1'b0, 20'd33);
  endtask

  task automatic t_rot;
    go("R10 rol32 by 33", 3'd4, 2'd0, 64'h9999_0000_8000_0001, 64'h0, 64'h0, 1'b0, 20'd33);
    go("R10 rol64 by 4", 3'd4, 2'd1, 64'hF000_0000_0000_000A, 64'h0, 64'h0, 1'b0, 20'd4);
    go("R10 rol pair", 3'd4, 2'd2, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001,
       64'h0, 1'b0, 20'd60);
  endtask

  task automatic t_hold;
    go("R11 set ovf", 3'd2, 2'd0, 64'h4000_0000, 64'h0, 64'h0, 1'b0, 20'd1);
    go("R11 sll keeps cc", 3'd0, 2'd1, 64'h5, 64'h0, 64'h0, 1'b0, 20'd1);
    go("R11 srl keeps cc", 3'd1, 2'd0, 64'h0, 64'h0, 64'h0, 1'b0, 20'd0);
    go("R11 rol keeps cc", 3'd4, 2'd1, 64'h1, 64'h0, 64'h0, 1'b0, 20'd1);
  endtask

  task automatic t_idle;
    logic [63:0] hi0, lo0;
    logic [1:0]  cc0;
    hi0 = res_hi; lo0 = res_lo; cc0 = cc;
    @(negedge clk);
    op_sel = 3'd2; width_sel = 2'd1; opnd_a = 64'hFFFF; opnd_b = 64'h1234; disp = 20'd9;
    @(posedge clk);
    #1;
    chk("R12 idle out_valid", 64'(out_valid), 64'd0);
    chk("R12 idle res_hi", res_hi, hi0);
    chk("R12 idle res_lo", res_lo, lo0);
    chk("R12 idle cc", 64'(cc), 64'(cc0));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; width_sel = '0;
    opnd_a = '0; opnd_b = '0; base = '0; base_vld = 1'b0; disp = '0;
    exp_cc = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_amount();
    t_big32();
    t_sra32();
    t_sla();
    t_sla63();
    t_sra_cc();
    t_pair();
    t_rot();
    t_hold();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog R12 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule